// File: doc/BRIEF.md
# Trapezoidal Threshold Trigger

This block watches one stream of signed 16-bit ADC samples, one sample per clock, and raises a trigger pulse when a shaped version of the stream crosses a programmable level. It keeps two moving sums of P samples each. The later window starts G clocks after the earlier one. Their difference is a trapezoidal value that sits near zero on a flat baseline and swings away from zero when the input steps. The value is compared either against the threshold (above mode) or against the negated threshold (below mode).

When the comparison first becomes true, the block loads a down-counter with the programmed pulse length, and the trigger output stays high while that counter is non-zero. One copy of the block serves one channel. The window lengths, pulse length, polarity and threshold come from setup registers held outside the block.

Top module: `trap_trig`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `trig_o` is 0. The delay history and both running sums start at zero, and the effective window lengths start at 1.
- R2: In above mode (`cfg_above_i` = 1), a trigger starts when the trapezoidal value is strictly greater than `thresh_i`. A value equal to the threshold does not start one. The trapezoidal value is the sum of the newest P samples minus the sum of the P samples that end G clocks earlier.
- R3: In below mode (`cfg_above_i` = 0), a trigger starts when the trapezoidal value is strictly less than the negated `thresh_i`.
- R4: The peaking length P is taken from `cfg_peak_i`. A value of 0 acts as 1, and a value above 16 acts as 16.
- R5: The gap G is taken from `cfg_gap_i`. A value of 0 acts as 1, and a value above 16 acts as 16.
- R6: A trigger starts only on the first cycle in which the comparison is true. No new trigger starts until the comparison has been false for at least one cycle.
- R7: `trig_o` rises one clock after the running sums hold a value that meets the condition. It then stays high for `cfg_pulse_len_i` cycles, where a length of 0 gives a one-cycle pulse.
- R8: A new trigger that starts while a pulse is still running reloads the full length, which extends the pulse.
- R9: On any clock where the effective P or G differs from the value used in the previous cycle, the delay history and both sums are cleared. The sample presented in that cycle is discarded.
- R10: With P = G = 16, samples at the full-scale limits of +32767 and -32768 produce the exact trapezoidal values ±524272 and -1048560 without wrap-around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_i | input | 16 | Signed two's-complement ADC sample, one per clock |
| cfg_peak_i | input | 5 | Raw peaking length P |
| cfg_gap_i | input | 5 | Raw gap length G |
| cfg_pulse_len_i | input | 8 | Trigger pulse length in clocks |
| cfg_above_i | input | 1 | 1 = above mode, 0 = below mode |
| thresh_i | input | 21 | Unsigned threshold magnitude |
| trig_o | output | 1 | Trigger pulse |

## Verification
Two functions can act in the same clock. A fresh crossing can reload a pulse that is still running, and a change of P or G can clear the history in the very cycle after a crossing has been detected. The bench provokes the first case with an input that crosses, drops back and crosses again within a long pulse. It provokes the second by changing P on a steady input so that the refill drives the trapezoid over the threshold. A cycle-exact reference model that clears its own history on each change of P or G produces the expected trigger for every clock, and any extra, missing or stretched cycle shows up as a mismatch at the exact clock where it occurs.

// File: rtl/trap_trig_pkg.sv
package trap_trig_pkg;
   localparam int DEF_SMP_W   = 16;
   localparam int DEF_MAX_WIN = 16;
   localparam int DEF_LEN_W   = 8;

   typedef enum logic {
      TRIG_BELOW = 1'b0,
      TRIG_ABOVE = 1'b1
   } trig_pol_e;
endpackage

// File: rtl/trap_win_clamp.sv
module trap_win_clamp #(
   parameter int MAX_WIN = 16,
   parameter int CFG_W   = 5
) (
   input  logic [CFG_W-1:0] raw_i,
   output logic [CFG_W-1:0] win_o
);
   localparam logic [CFG_W-1:0] WIN_MIN = CFG_W'(1);
   localparam logic [CFG_W-1:0] WIN_MAX = CFG_W'(MAX_WIN);

   always_comb begin
      if (raw_i == '0)
         win_o = WIN_MIN;
      else if (raw_i > WIN_MAX)
         win_o = WIN_MAX;
      else
         win_o = raw_i;
   end
endmodule

// File: rtl/trap_hist_sum.sv
module trap_hist_sum #(
   parameter int SMP_W   = 16,
   parameter int MAX_WIN = 16,
   parameter int CFG_W   = 5,
   parameter int SUM_W   = 22
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [SMP_W-1:0]        sample_i,
   input  logic [CFG_W-1:0]        peak_i,
   input  logic [CFG_W-1:0]        gap_i,
   output logic signed [SUM_W-1:0] trap_o,
   output logic signed [SUM_W-1:0] sum_early_o,
   output logic signed [SUM_W-1:0] sum_late_o,
   output logic [CFG_W-1:0]        peak_q_o,
   output logic [CFG_W-1:0]        gap_q_o,
   output logic                    flush_o
);
   localparam int DEPTH = 2 * MAX_WIN;
   localparam int IDX_W = $clog2(DEPTH);

   logic [SMP_W-1:0]        hist_q [DEPTH];
   logic signed [SUM_W-1:0] sum_early_q, sum_late_q;
   logic [CFG_W-1:0]        peak_q, gap_q;
   logic [IDX_W-1:0]        idx_p, idx_g, idx_gp;
   logic                    flush;

   function automatic logic signed [SUM_W-1:0] sx(input logic [SMP_W-1:0] v);
      return {{(SUM_W-SMP_W){v[SMP_W-1]}}, v};
   endfunction

   always_comb begin
      idx_p  = IDX_W'({1'b0, peak_q} - 1'b1);
      idx_g  = IDX_W'({1'b0, gap_q} - 1'b1);
      idx_gp = IDX_W'({1'b0, peak_q} + {1'b0, gap_q} - 1'b1);
      flush  = (peak_i != peak_q) || (gap_i != gap_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) hist_q[k] <= '0;
         sum_early_q <= '0;
         sum_late_q  <= '0;
         peak_q      <= CFG_W'(1);
         gap_q       <= CFG_W'(1);
      end else begin
         peak_q <= peak_i;
         gap_q  <= gap_i;
         if (flush) begin
            for (int k = 0; k < DEPTH; k++) hist_q[k] <= '0;
            sum_early_q <= '0;
            sum_late_q  <= '0;
         end else begin
            hist_q[0] <= sample_i;
            for (int k = 1; k < DEPTH; k++) hist_q[k] <= hist_q[k-1];
            sum_late_q  <= sum_late_q + sx(sample_i) - sx(hist_q[idx_p]);
            sum_early_q <= sum_early_q + sx(hist_q[idx_g]) - sx(hist_q[idx_gp]);
         end
      end
   end

   assign trap_o      = sum_late_q - sum_early_q;
   assign sum_early_o = sum_early_q;
   assign sum_late_o  = sum_late_q;
   assign peak_q_o    = peak_q;
   assign gap_q_o     = gap_q;
   assign flush_o     = flush;
endmodule

// File: rtl/trap_cmp_edge.sv
module trap_cmp_edge
   import trap_trig_pkg::*;
#(
   parameter int SUM_W = 22,
   parameter int THR_W = 21
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic signed [SUM_W-1:0] trap_i,
   input  logic [THR_W-1:0]        thr_i,
   input  logic                    above_i,
   output logic                    fire_o
);
   logic signed [SUM_W-1:0] thr_s;
   logic                    cond, cond_q;

   always_comb begin
      thr_s = {{(SUM_W-THR_W){1'b0}}, thr_i};
      if (trig_pol_e'(above_i) == TRIG_ABOVE)
         cond = trap_i > thr_s;
      else
         cond = trap_i < -thr_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cond_q <= 1'b0;
      else        cond_q <= cond;
   end

   assign fire_o = cond & ~cond_q;
endmodule

// File: rtl/trap_pulse.sv
module trap_pulse #(
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire_i,
   input  logic [LEN_W-1:0] len_i,
   output logic [LEN_W-1:0] cnt_o,
   output logic             trig_o
);
   logic [LEN_W-1:0] cnt_q, load;

   assign load = (len_i == '0) ? LEN_W'(1) : len_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (fire_i)        cnt_q <= load;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign cnt_o  = cnt_q;
   assign trig_o = cnt_q != '0;
endmodule

// File: rtl/trap_trig.sv
module trap_trig
   import trap_trig_pkg::*;
#(
   parameter int SMP_W   = DEF_SMP_W,
   parameter int MAX_WIN = DEF_MAX_WIN,
   parameter int LEN_W   = DEF_LEN_W,
   localparam int CFG_W  = $clog2(MAX_WIN + 1),
   localparam int SUM_W  = SMP_W + CFG_W + 1,
   localparam int THR_W  = SUM_W - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SMP_W-1:0] sample_i,
   input  logic [CFG_W-1:0] cfg_peak_i,
   input  logic [CFG_W-1:0] cfg_gap_i,
   input  logic [LEN_W-1:0] cfg_pulse_len_i,
   input  logic             cfg_above_i,
   input  logic [THR_W-1:0] thresh_i,
   output logic             trig_o
);
   generate
      if (SMP_W < 2) begin : g_bad_smp
         $error("trap_trig: SMP_W must be at least 2");
      end
      if (MAX_WIN < 1) begin : g_bad_win
         $error("trap_trig: MAX_WIN must be at least 1");
      end
      if (LEN_W < 1) begin : g_bad_len
         $error("trap_trig: LEN_W must be at least 1");
      end
   endgenerate

   logic [CFG_W-1:0]        peak_eff, gap_eff, peak_q, gap_q;
   logic signed [SUM_W-1:0] trap, sum_early, sum_late;
   logic                    flush, fire;
   logic [LEN_W-1:0]        pulse_cnt;

   trap_win_clamp #(.MAX_WIN(MAX_WIN), .CFG_W(CFG_W)) u_clamp_peak (
      .raw_i(cfg_peak_i), .win_o(peak_eff));

   trap_win_clamp #(.MAX_WIN(MAX_WIN), .CFG_W(CFG_W)) u_clamp_gap (
      .raw_i(cfg_gap_i), .win_o(gap_eff));

   trap_hist_sum #(.SMP_W(SMP_W), .MAX_WIN(MAX_WIN), .CFG_W(CFG_W), .SUM_W(SUM_W)) u_sum (
      .clk(clk), .rst_n(rst_n), .sample_i(sample_i),
      .peak_i(peak_eff), .gap_i(gap_eff),
      .trap_o(trap), .sum_early_o(sum_early), .sum_late_o(sum_late),
      .peak_q_o(peak_q), .gap_q_o(gap_q), .flush_o(flush));

   trap_cmp_edge #(.SUM_W(SUM_W), .THR_W(THR_W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .trap_i(trap), .thr_i(thresh_i),
      .above_i(cfg_above_i), .fire_o(fire));

   trap_pulse #(.LEN_W(LEN_W)) u_pulse (
      .clk(clk), .rst_n(rst_n), .fire_i(fire), .len_i(cfg_pulse_len_i),
      .cnt_o(pulse_cnt), .trig_o(trig_o));
endmodule

// File: rtl/trap_trig_chk.sv
module trap_trig_chk #(
   parameter int SMP_W   = 16,
   parameter int MAX_WIN = 16,
   parameter int CFG_W   = 5,
   parameter int SUM_W   = 22,
   parameter int LEN_W   = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    trig_o,
   input logic                    fire,
   input logic                    flush,
   input logic [LEN_W-1:0]        pulse_cnt,
   input logic [CFG_W-1:0]        peak_q,
   input logic [CFG_W-1:0]        gap_q,
   input logic signed [SUM_W-1:0] sum_early,
   input logic signed [SUM_W-1:0] sum_late
);
   localparam int LIM = MAX_WIN * (2 ** (SMP_W - 1));

   p_peak_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (peak_q >= CFG_W'(1)) && (peak_q <= CFG_W'(MAX_WIN)));

   p_gap_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (gap_q >= CFG_W'(1)) && (gap_q <= CFG_W'(MAX_WIN)));

   p_single_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !fire);

   p_pulse_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> trig_o);

   p_pulse_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!fire && pulse_cnt != '0) |=> (pulse_cnt == $past(pulse_cnt) - 1'b1));

   p_flush_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (sum_early == '0) && (sum_late == '0));

   p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(sum_late) <= LIM) && (int'(sum_late) >= -LIM) &&
      (int'(sum_early) <= LIM) && (int'(sum_early) >= -LIM));
endmodule

bind trap_trig trap_trig_chk #(
   .SMP_W(SMP_W), .MAX_WIN(MAX_WIN), .CFG_W(CFG_W), .SUM_W(SUM_W), .LEN_W(LEN_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .trig_o(trig_o), .fire(fire), .flush(flush),
   .pulse_cnt(pulse_cnt), .peak_q(peak_q), .gap_q(gap_q),
   .sum_early(sum_early), .sum_late(sum_late));

// File: tb/trap_trig_tb.sv
`timescale 1ns/100ps
module trap_trig_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] sample_i = '0;
   logic [4:0]  cfg_peak_i = '0;
   logic [4:0]  cfg_gap_i = '0;
   logic [7:0]  cfg_pulse_len_i = '0;
   logic        cfg_above_i = 1'b0;
   logic [20:0] thresh_i = '0;
   logic        trig_o;

   always #2.5 clk = ~clk;

   trap_trig u_dut (
      .clk(clk), .rst_n(rst_n), .sample_i(sample_i),
      .cfg_peak_i(cfg_peak_i), .cfg_gap_i(cfg_gap_i),
      .cfg_pulse_len_i(cfg_pulse_len_i), .cfg_above_i(cfg_above_i),
      .thresh_i(thresh_i), .trig_o(trig_o));

   typedef struct {
      logic  trig;
      string tag;
   } exp_t;

   exp_t sb[$];
   int   n_checks = 0;
   int   n_errors = 0;
   bit   done = 0;

   // settings applied by the driver at each falling edge
   int    s_peak = 0, s_gap = 0, s_len = 0, s_thr = 0;
   bit    s_above = 0;

   // reference model state
   int h[32];
   int m_pk = 1, m_gp = 1, m_cnt = 0;
   bit m_cond_q = 0;

   function automatic int clampw(int v);
      if (v == 0) return 1;
      if (v > 16) return 16;
      return v;
   endfunction

   task automatic check(bit ok, string tag, int act, int expv);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, expv, $time);
      end
   endtask

   task automatic model_step(int smp);
      int trap, s2, s1, np, ng, ld;
      bit cond, fire;
      s2 = 0; s1 = 0;
      for (int k = 0; k < m_pk; k++) s2 += h[k];
      for (int k = 0; k < m_pk; k++) s1 += h[m_gp + k];
      trap = s2 - s1;
      cond = s_above ? (trap > s_thr) : (trap < -s_thr);
      fire = cond && !m_cond_q;
      m_cond_q = cond;
      ld = (s_len == 0) ? 1 : s_len;
      if (fire) m_cnt = ld;
      else if (m_cnt > 0) m_cnt--;
      np = clampw(s_peak);
      ng = clampw(s_gap);
      if (np != m_pk || ng != m_gp) begin
         for (int k = 0; k < 32; k++) h[k] = 0;
      end else begin
         for (int k = 31; k > 0; k--) h[k] = h[k-1];
         h[0] = smp;
      end
      m_pk = np;
      m_gp = ng;
   endtask

   // driver: one sample per clock, expected trigger pushed to the scoreboard
   task automatic drive(int smp, int n, string tag);
      exp_t e;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         sample_i        = 16'(smp);
         cfg_peak_i      = 5'(s_peak);
         cfg_gap_i       = 5'(s_gap);
         cfg_pulse_len_i = 8'(s_len);
         cfg_above_i     = s_above;
         thresh_i        = 21'(s_thr);
         @(posedge clk);
         model_step(smp);
         e.trig = (m_cnt != 0);
         e.tag  = tag;
         sb.push_back(e);
      end
   endtask

   task automatic setup(int p, int g, bit above, int thr, int len);
      s_peak = p; s_gap = g; s_above = above; s_thr = thr; s_len = len;
   endtask

   // monitor: compares the output away from the active edge
   always @(posedge clk) begin
      #1;
      while (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         check(trig_o === e.trig, e.tag, int'(trig_o), int'(e.trig));
      end
   end

   initial begin
      #1000000;
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < 32; k++) h[k] = 0;
      repeat (4) @(negedge clk);
      check(trig_o === 1'b0, "R1 idle during reset", int'(trig_o), 0);
      rst_n = 1'b1;
      drive(0, 3, "R1 idle after reset");

      // R2/R6: plateau of 400 with P=4, G=8
      setup(4, 8, 1, 399, 3);
      drive(0, 10, "R2 baseline");
      drive(100, 20, "R2 R6 above crossing");
      drive(0, 20, "R2 return");
      setup(4, 8, 1, 400, 3);
      drive(100, 20, "R2 equal not above");
      drive(0, 20, "R2 equal not above");

      // R3: below mode
      setup(4, 8, 0, 399, 4);
      drive(0, 10, "R3 baseline");
      drive(-100, 20, "R3 below crossing");
      drive(0, 20, "R3 return");

      // R4: peaking clamp
      setup(0, 1, 1, 999, 2);
      drive(0, 4, "R4 peak zero");
      drive(1000, 6, "R4 peak zero acts as one");
      drive(0, 6, "R4 peak zero");
      setup(20, 16, 1, 799, 2);
      drive(50, 40, "R4 peak above max");
      drive(0, 40, "R4 peak above max");
      setup(20, 16, 1, 800, 2);
      drive(50, 40, "R4 peak limit equal");
      drive(0, 40, "R4 peak limit equal");

      // R5: gap clamp seen in trigger delay
      setup(1, 31, 0, 5, 1);
      drive(0, 20, "R5 gap above max");
      drive(10, 1, "R5 gap above max");
      drive(0, 25, "R5 gap above max delay");
      setup(1, 0, 0, 5, 1);
      drive(0, 20, "R5 gap zero");
      drive(10, 1, "R5 gap zero");
      drive(0, 10, "R5 gap zero delay");

      // R7: pulse lengths
      setup(1, 1, 1, 50, 0);
      drive(0, 3, "R7 len zero");
      drive(100, 1, "R7 len zero");
      drive(0, 6, "R7 len zero one cycle");
      setup(1, 1, 1, 50, 5);
      drive(0, 3, "R7 len five");
      drive(100, 1, "R7 len five");
      drive(0, 8, "R7 len five");
      setup(1, 1, 1, 50, 255);
      drive(0, 3, "R7 len max");
      drive(100, 1, "R7 len max");
      drive(0, 260, "R7 len max");

      // R8: retrigger during an active pulse
      setup(1, 1, 1, 50, 20);
      drive(0, 3, "R8 retrigger");
      drive(100, 1, "R8 retrigger first");
      drive(0, 2, "R8 retrigger gap");
      drive(100, 1, "R8 retrigger second");
      drive(0, 30, "R8 reload extends");

      // R9: config change clears history, refill crosses
      setup(4, 4, 1, 450, 2);
      drive(100, 20, "R9 steady");
      setup(5, 4, 1, 450, 2);
      drive(100, 20, "R9 flush refill");
      drive(0, 20, "R9 tail");

      // R10: full-scale extremes
      setup(16, 16, 1, 524271, 4);
      drive(0, 40, "R10 baseline");
      drive(32767, 40, "R10 positive full scale");
      setup(16, 16, 0, 1048559, 4);
      drive(-32768, 40, "R10 negative full swing");
      drive(0, 40, "R10 return");

      repeat (3) @(negedge clk);
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule